// File: doc/BRIEF.md
# Address-Map Chip-Select Decoder

This block turns the 20-bit address of a small microcontroller into device selects for three targets on an 8-bit data bus: a 4 KiB program ROM at the bottom of the map, an 8 KiB data RAM placed directly above it, and a four-register character display window at 60K (0x0F000). Every address bit takes part in the decode, so any non-zero value on A19..A16 aliases nothing. The memory selects are active low and the display select is active high. There is no clock: each output follows the present address and strobes through gate logic only.

The CPU read and write strobes are active low. They are gated by the decoded selects to form the read and write enables for the bus. A write aimed at the ROM window produces no write enable and is flagged as an error. The two lowest address bits are presented as a register index while the display is selected.

Top module: `chip_sel_decoder`

## Requirements
- R1: `rom_sel_n` is 0 exactly for addresses 0x00000 through 0x00FFF, and 1 otherwise.
- R2: `ram_sel_n` is 0 exactly for addresses 0x01000 through 0x02FFF, and 1 otherwise.
- R3: `lcd_sel` is 1 exactly for addresses 0x0F000 through 0x0F003, and 0 otherwise.
- R4: When any of address bits 19..16 is 1, no select is asserted.
- R5: At most one of the three selects is asserted for any address.
- R6: For an address outside all three windows, `decode_err` is 1 and no select is asserted.
- R7: `rd_en_n` is 0 exactly when `rd_n` is 0 and one of the three selects is asserted.
- R8: `wr_en_n` is 0 exactly when `wr_n` is 0 and either the RAM or the display is selected. With `wr_n` at 0 in the ROM window, `wr_en_n` stays 1 and `decode_err` is 1.
- R9: `lcd_reg` equals address bits 1..0 while `lcd_sel` is 1, and is 2'b00 otherwise.
- R10: The three selects depend on the address alone. Changing `rd_n` or `wr_n` does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 20 | CPU address bus A19..A0 |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| rom_sel_n | output | 1 | ROM select, active low |
| ram_sel_n | output | 1 | RAM select, active low |
| lcd_sel | output | 1 | Display select, active high |
| rd_en_n | output | 1 | Gated read enable, active low |
| wr_en_n | output | 1 | Gated write enable, active low |
| decode_err | output | 1 | Unmapped address, or a write to ROM |
| lcd_reg | output | 2 | Display register index |

## Verification
The bench sweeps the whole lower 64K of the map and compares it against window bounds it computes arithmetically. This catches an off-by-one at 0x00FFF/0x01000, at 0x02FFF/0x03000 and at both edges of the display window. A RAM matcher that covers only one 4K block, or one that is aligned to 8K, would lose half of the RAM or select 0x00000 as RAM. Sample addresses with each upper nibble 1..15 show whether the decoder drops A19..A16, which would make every window appear sixteen times. Every strobe combination is applied at the display and ROM windows, which exposes a write enable that leaks into ROM, a missing error flag, or a select that wrongly depends on a strobe.

// File: rtl/addr_map_pkg.sv
package addr_map_pkg;
  localparam int ADDR_W = 20;

  localparam int ROM_LOG2_BLK = 12;
  localparam int ROM_NBLK = 1;
  localparam logic [ADDR_W-1:0] ROM_BASE = 20'h00000;

  localparam int RAM_LOG2_BLK = 12;
  localparam int RAM_NBLK = 2;
  localparam logic [ADDR_W-1:0] RAM_BASE = 20'h01000;

  localparam int LCD_LOG2_BLK = 2;
  localparam int LCD_NBLK = 1;
  localparam logic [ADDR_W-1:0] LCD_BASE = 20'h0F000;

  typedef struct packed {
    logic rom;
    logic ram;
    logic lcd;
  } hit_t;
endpackage

// File: rtl/region_match.sv
module region_match #(
  parameter int AW = 20,
  parameter int LOG2_BLK = 12,
  parameter int NBLK = 1,
  parameter logic [AW-1:0] BASE = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam int TAGW = AW - LOG2_BLK;

  logic [NBLK-1:0] blk_hit;

  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    localparam logic [AW-1:0] BLK_BASE = BASE + (AW'(b) << LOG2_BLK);
    logic [TAGW-1:0] bit_eq;
    for (genvar i = 0; i < TAGW; i++) begin : g_bit
      if (BLK_BASE[LOG2_BLK+i]) begin : g_one
        assign bit_eq[i] = addr[LOG2_BLK+i];
      end else begin : g_zero
        assign bit_eq[i] = ~addr[LOG2_BLK+i];
      end
    end
    assign blk_hit[b] = &bit_eq;
  end

  assign hit = |blk_hit;
endmodule

// File: rtl/strobe_gate.sv
module strobe_gate
  import addr_map_pkg::*;
(
  input  hit_t       hits,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr_lo,
  output logic       rd_en_n,
  output logic       wr_en_n,
  output logic       decode_err,
  output logic [1:0] lcd_reg
);
  logic any_hit;
  logic wr_ok;

  always_comb begin
    any_hit    = hits.rom | hits.ram | hits.lcd;
    wr_ok      = hits.ram | hits.lcd;
    rd_en_n    = ~(~rd_n & any_hit);
    wr_en_n    = ~(~wr_n & wr_ok);
    decode_err = ~any_hit | (hits.rom & ~wr_n);
    lcd_reg    = addr_lo & {2{hits.lcd}};
  end

  always_comb begin
    AST_NO_ROM_WRITE: assert (!(hits.rom && !wr_en_n)); // R8
    AST_RD_NEEDS_SEL: assert (rd_en_n || any_hit); // R7
    AST_IDX_IDLE: assert (hits.lcd || lcd_reg == 2'b00); // R9
  end
endmodule

// File: rtl/chip_sel_decoder.sv
module chip_sel_decoder
  import addr_map_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  input  logic          rd_n,
  input  logic          wr_n,
  output logic          rom_sel_n,
  output logic          ram_sel_n,
  output logic          lcd_sel,
  output logic          rd_en_n,
  output logic          wr_en_n,
  output logic          decode_err,
  output logic [1:0]    lcd_reg
);
  hit_t hits;

  region_match #(.AW(AW), .LOG2_BLK(ROM_LOG2_BLK), .NBLK(ROM_NBLK), .BASE(AW'(ROM_BASE)))
    u_rom_match (.addr(addr), .hit(hits.rom));

  region_match #(.AW(AW), .LOG2_BLK(RAM_LOG2_BLK), .NBLK(RAM_NBLK), .BASE(AW'(RAM_BASE)))
    u_ram_match (.addr(addr), .hit(hits.ram));

  region_match #(.AW(AW), .LOG2_BLK(LCD_LOG2_BLK), .NBLK(LCD_NBLK), .BASE(AW'(LCD_BASE)))
    u_lcd_match (.addr(addr), .hit(hits.lcd));

  strobe_gate u_gate (
    .hits      (hits),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .addr_lo   (addr[1:0]),
    .rd_en_n   (rd_en_n),
    .wr_en_n   (wr_en_n),
    .decode_err(decode_err),
    .lcd_reg   (lcd_reg)
  );

  assign rom_sel_n = ~hits.rom;
  assign ram_sel_n = ~hits.ram;
  assign lcd_sel   = hits.lcd;

  always_comb begin
    AST_ONE_SEL: assert ($countones({~rom_sel_n, ~ram_sel_n, lcd_sel}) <= 1); // R5
    AST_UPPER_ZERO: assert (!(|addr[AW-1:16]) || (rom_sel_n && ram_sel_n && !lcd_sel)); // R4
    AST_ERR_NO_SEL: assert (!decode_err || !wr_n || (rom_sel_n && ram_sel_n && !lcd_sel)); // R6
  end
endmodule

// File: tb/chip_sel_decoder_tb.sv
module chip_sel_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 60000;

  logic        clk;
  logic        rst_n;
  logic [19:0] addr;
  logic        rd_n, wr_n;
  logic        rom_sel_n, ram_sel_n, lcd_sel, rd_en_n, wr_en_n, decode_err;
  logic [1:0]  lcd_reg;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  chip_sel_decoder u_dut (
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
    .rom_sel_n(rom_sel_n), .ram_sel_n(ram_sel_n), .lcd_sel(lcd_sel),
    .rd_en_n(rd_en_n), .wr_en_n(wr_en_n), .decode_err(decode_err),
    .lcd_reg(lcd_reg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp, input logic [19:0] a);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s addr=%05h rd_n=%0b wr_n=%0b actual=%0d expected=%0d", req, a, rd_n, wr_n, act, exp);
    end
  endtask

  task automatic apply_check(input logic [19:0] a, input logic r, input logic w);
    bit e_rom, e_ram, e_lcd, e_any, e_err;
    addr = a; rd_n = r; wr_n = w;
    #(CLK_PERIOD/5);
    e_rom = (a < 20'h01000);
    e_ram = (a >= 20'h01000) && (a < 20'h03000);
    e_lcd = (a >= 20'h0F000) && (a < 20'h0F004);
    e_any = e_rom | e_ram | e_lcd;
    e_err = !e_any || (e_rom && !w);
    chk("R1 rom_sel_n", int'(rom_sel_n), int'(!e_rom), a);
    chk("R2 ram_sel_n", int'(ram_sel_n), int'(!e_ram), a);
    chk("R3 lcd_sel", int'(lcd_sel), int'(e_lcd), a);
    chk("R7 rd_en_n", int'(rd_en_n), int'(!(!r && e_any)), a);
    chk("R8 wr_en_n", int'(wr_en_n), int'(!(!w && (e_ram || e_lcd))), a);
    chk("R6 decode_err", int'(decode_err), int'(e_err), a);
    chk("R9 lcd_reg", int'(lcd_reg), e_lcd ? int'(a[1:0]) : 0, a);
    chk("R5 one select", $countones({!rom_sel_n, !ram_sel_n, lcd_sel}) <= 1 ? 1 : 0, 1, a);
  endtask

  initial begin
    rst_n = 1'b0;
    addr = '0; rd_n = 1'b1; wr_n = 1'b1;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state after reset: address 0, strobes idle
    chk("R1 reset rom_sel_n", int'(rom_sel_n), 0, addr);
    chk("R7 reset rd_en_n", int'(rd_en_n), 1, addr);
    chk("R8 reset wr_en_n", int'(wr_en_n), 1, addr);

    // lower 64K sweep, strobes varied with the address
    for (int a = 0; a < 65536; a++) begin
      int st = (a * 7 + (a >> 4)) & 3;
      apply_check(20'(a), st[0], st[1]);
    end

    // R4: each non-zero upper nibble
    for (int hi = 1; hi < 16; hi++) begin
      apply_check({4'(hi), 16'h0000}, 1'b0, 1'b1);
      apply_check({4'(hi), 16'h1000}, 1'b1, 1'b0);
      apply_check({4'(hi), 16'h2FFF}, 1'b0, 1'b1);
      apply_check({4'(hi), 16'hF003}, 1'b1, 1'b0);
      chk("R4 no select high", int'(rom_sel_n & ram_sel_n & !lcd_sel), 1, addr);
    end

    // R10: selects fixed across all strobe pairs
    for (int k = 0; k < 6; k++) begin
      logic [19:0] pa;
      logic s_rom, s_ram, s_lcd;
      case (k)
        0: pa = 20'h00FFF; 1: pa = 20'h01000; 2: pa = 20'h02FFF;
        3: pa = 20'h0F000; 4: pa = 20'h0F003; default: pa = 20'h0F004;
      endcase
      apply_check(pa, 1'b1, 1'b1);
      s_rom = rom_sel_n; s_ram = ram_sel_n; s_lcd = lcd_sel;
      for (int s = 0; s < 4; s++) begin
        apply_check(pa, s[0], s[1]);
        chk("R10 sel stable", int'({rom_sel_n, ram_sel_n, lcd_sel}), int'({s_rom, s_ram, s_lcd}), pa);
      end
    end

    // R8: explicit ROM write
    apply_check(20'h00800, 1'b1, 1'b0);
    chk("R8 rom write blocked", int'(wr_en_n), 1, addr);
    chk("R8 rom write flagged", int'(decode_err), 1, addr);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYCLES; c++) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule